// File: doc/BRIEF.md
# Serial control and status port

This block is the register access port of a tone signalling line interface. A host talks to it over three wires: a serial clock, an enable strobe and one shared data pin, plus a direction line that chooses between writing control bits and reading the decoded digit. The host writes a 14-bit control word that sets the operating mode, the transmit squelch, the detect guard-time selection, the attenuation/gain code and the tone code. It reads back the 4-bit digit most recently reported by the tone decoder.

In write direction, bits are shifted into a shadow register on rising serial-clock edges. They reach the mode outputs only while the enable is high, and they reach them at once. While the enable is low, the outputs keep their last applied value, so the host can shift a new word in the background. Serial-clock edges that arrive while the enable is high are ignored, which keeps the applied word stable. In read direction, an enable rising edge takes a snapshot of the decoder's digit and puts its least significant bit on the data pin. The following serial-clock rising edges step through the remaining bits, and then wrap back to the first bit.

All serial inputs are asynchronous to the system clock. They pass through two-flop synchronisers, and their edges are detected in the system clock domain. The shared pin is modelled as a data output plus an output-enable.

Top module: `tone_ctrl_serial_port`

## Requirements
- R1: In write direction (ser_dir_i low) the word is shifted in on rising serial-clock edges, first bit to last: tone[3:0] MSB first, level[3:0] MSB first, guard_sel[1:0] MSB first, squelch, mode[2:0] MSB first.
- R2: While ser_en_i is high and ser_dir_i is low, the shadow word is driven onto tone_o, level_o, guard_sel_o, squelch_o and mode_o within a few system clocks.
- R3: While ser_en_i is low, shifting a new word changes none of the applied outputs.
- R4: In read direction (ser_dir_i high), a rising edge of ser_en_i captures digit_i, raises ser_data_oe_o and drives digit bit 0 on ser_data_o.
- R5: In read direction, the next three serial-clock rising edges present digit bits 1, 2 and 3 in turn.
- R6: Further serial-clock edges wrap the output back to bit 0 and repeat the captured value. Changes on digit_i do not affect the output until the next enable rising edge, which captures the latest digit.
- R7: When ser_dir_i is low, ser_data_oe_o is low and ser_data_o is 0. The captured read value is discarded, so returning to read direction without an enable edge leaves the output enable low.
- R8: Mode codes 000 receive, 001 transmit, 010 single tone, 011 power-down 1, 100 power-down 2 and 101 loopback appear unchanged on mode_o. Codes 110 and 111 appear as 100.
- R9: Serial-clock edges while ser_en_i is high in write direction are ignored: the shadow word and the applied outputs do not change.
- R10: After reset all applied outputs are 0 (receive mode), and ser_data_oe_o and ser_data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_en_i | input | 1 | Enable strobe: applies the word in write direction, captures the digit in read direction |
| ser_dir_i | input | 1 | Direction: 0 write, 1 read |
| ser_data_i | input | 1 | Data pin input value |
| ser_data_o | output | 1 | Data pin output value |
| ser_data_oe_o | output | 1 | Data pin output enable |
| digit_i | input | 4 | Digit from the tone decoder |
| mode_o | output | 3 | Applied operating mode |
| squelch_o | output | 1 | Applied transmit squelch |
| guard_sel_o | output | 2 | Applied detect guard-time selection |
| level_o | output | 4 | Applied attenuation/gain code |
| tone_o | output | 4 | Applied tone code |

## Verification
The write sweep shifts sixteen words. Each uses a different tone code, its complement as the level code, and a different guard, squelch and mode value, so every mode code including 110 and 111 appears. A swapped field boundary or a reversed bit order then shows up as a wrong value in a named field. Background shifting with the enable low, and toggling the serial clock with the enable held high, separate a correct hold from a port that applies or shifts too eagerly. The read sweep covers all sixteen digits and walks past bit 3 to show the wrap. It changes digit_i mid-read to tell a snapshot apart from a live view, then drops and restores the direction line to confirm the captured value is discarded.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int CTRL_W  = 14;
  localparam int DIGIT_W = 4;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    MODE_RX   = 3'b000,
    MODE_TX   = 3'b001,
    MODE_TONE = 3'b010,
    MODE_PD1  = 3'b011,
    MODE_PD2  = 3'b100,
    MODE_LOOP = 3'b101
  } mode_e;

  // Packed so that the first bit shifted in lands in the most significant bit.
  typedef struct packed {
    logic [3:0] tone;
    logic [3:0] level;
    logic [1:0] guard;
    logic       squelch;
    logic [2:0] mode;
  } ctrl_t;

  function automatic logic [2:0] fold_mode(input logic [2:0] code);
    return (code > MODE_LOOP) ? MODE_PD2 : code;
  endfunction
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_d, chain_q;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-W-1:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/sps_edge.sv
module sps_edge #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sps_wr_path.sv
module sps_wr_path
  import sps_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sck_rise_i,
  input  logic  en_lvl_i,
  input  logic  dir_lvl_i,
  input  logic  sdi_lvl_i,
  output ctrl_t applied_o
);
  logic  write_sel;
  logic  shift_en, apply_en;
  logic [CTRL_W-1:0] shadow_d, shadow_q;
  ctrl_t applied_d, applied_q;

  assign write_sel = ~dir_lvl_i;
  assign shift_en  = write_sel & ~en_lvl_i & sck_rise_i;
  assign apply_en  = write_sel & en_lvl_i;

  always_comb begin
    shadow_d  = shadow_q;
    applied_d = applied_q;
    if (shift_en) shadow_d  = {shadow_q[CTRL_W-2:0], sdi_lvl_i};
    if (apply_en) applied_d = ctrl_t'(shadow_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q  <= '0;
      applied_q <= '0;
    end else begin
      if (shift_en) shadow_q  <= shadow_d;
      if (apply_en) applied_q <= applied_d;
    end
  end

  assign applied_o = applied_q;

  AST_SHADOW_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_lvl_i && !dir_lvl_i) |=> $stable(shadow_q)); // R9
  AST_APPLIED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_lvl_i && !dir_lvl_i) |=> $stable(applied_q)); // R3
  AST_APPLY_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_lvl_i && !dir_lvl_i) |=> (applied_q == ctrl_t'($past(shadow_q)))); // R2
endmodule

// File: rtl/sps_rd_path.sv
module sps_rd_path #(
  parameter int DIGIT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_rise_i,
  input  logic               en_rise_i,
  input  logic               dir_lvl_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic               sdo_o,
  output logic               sdo_oe_o
);
  localparam int IDX_W = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIGIT_W - 1);

  logic [DIGIT_W-1:0] data_d, data_q;
  logic [IDX_W-1:0]   idx_d, idx_q;
  logic               active_d, active_q;

  always_comb begin
    data_d   = data_q;
    idx_d    = idx_q;
    active_d = active_q;
    if (!dir_lvl_i) begin
      data_d   = '0;
      idx_d    = '0;
      active_d = 1'b0;
    end else if (en_rise_i) begin
      data_d   = digit_i;
      idx_d    = '0;
      active_d = 1'b1;
    end else if (sck_rise_i && active_q) begin
      idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
    end else begin
      data_q   <= data_d;
      idx_q    <= idx_d;
      active_q <= active_d;
    end
  end

  assign sdo_o    = active_q & data_q[idx_q];
  assign sdo_oe_o = active_q;

  AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_lvl_i && en_rise_i) |=> (sdo_oe_o && idx_q == '0)); // R4
  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_lvl_i && !en_rise_i && sck_rise_i && sdo_oe_o && idx_q == LAST_IDX) |=> (idx_q == '0)); // R6
  AST_SNAPSHOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_lvl_i && !en_rise_i) |=> $stable(data_q)); // R6
  AST_OE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_lvl_i |=> (!sdo_oe_o && !sdo_o)); // R7
endmodule

// File: rtl/tone_ctrl_serial_port.sv
module tone_ctrl_serial_port
  import sps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ser_clk_i,
  input  logic       ser_en_i,
  input  logic       ser_dir_i,
  input  logic       ser_data_i,
  output logic       ser_data_o,
  output logic       ser_data_oe_o,
  input  logic [3:0] digit_i,
  output logic [2:0] mode_o,
  output logic       squelch_o,
  output logic [1:0] guard_sel_o,
  output logic [3:0] level_o,
  output logic [3:0] tone_o
);
  localparam int NUM_IN   = 4;
  localparam int NUM_EDGE = 2;

  logic [1:0]          rst_sync_q;
  logic                rst_n_int;
  logic [NUM_IN-1:0]   raw_in, sync_lvl;
  logic [NUM_EDGE-1:0] edge_rise;
  logic                sck_lvl, en_lvl, dir_lvl, sdi_lvl;
  logic                sck_rise, en_rise;
  ctrl_t               applied;

  // Reset asserted asynchronously, released on the clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign raw_in = {ser_data_i, ser_dir_i, ser_en_i, ser_clk_i};

  sps_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (raw_in),
    .q_o    (sync_lvl)
  );

  assign {sdi_lvl, dir_lvl, en_lvl, sck_lvl} = sync_lvl;

  sps_edge #(.W(NUM_EDGE)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .lvl_i  ({en_lvl, sck_lvl}),
    .rise_o (edge_rise)
  );

  assign {en_rise, sck_rise} = edge_rise;

  sps_wr_path i_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .sck_rise_i (sck_rise),
    .en_lvl_i   (en_lvl),
    .dir_lvl_i  (dir_lvl),
    .sdi_lvl_i  (sdi_lvl),
    .applied_o  (applied)
  );

  sps_rd_path #(.DIGIT_W(DIGIT_W)) i_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .sck_rise_i (sck_rise),
    .en_rise_i  (en_rise),
    .dir_lvl_i  (dir_lvl),
    .digit_i    (digit_i),
    .sdo_o      (ser_data_o),
    .sdo_oe_o   (ser_data_oe_o)
  );

  assign mode_o      = fold_mode(applied.mode);
  assign squelch_o   = applied.squelch;
  assign guard_sel_o = applied.guard;
  assign level_o     = applied.level;
  assign tone_o      = applied.tone;

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (mode_o <= MODE_LOOP)); // R8
  AST_MODE_FOLD: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (applied.mode[2] && applied.mode[1]) |-> (mode_o == MODE_PD2)); // R8
endmodule

// File: tb/test_tone_ctrl_serial_port.sv
module test_tone_ctrl_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, en = 1'b0, dir = 1'b0, sdi = 1'b0;
  logic       sdo, sdo_oe;
  logic [3:0] digit = 4'h0;
  logic [2:0] mode;
  logic       sq;
  logic [1:0] guard;
  logic [3:0] level, tone;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tone_ctrl_serial_port i_tone_ctrl_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sck), .ser_en_i(en),
    .ser_dir_i(dir), .ser_data_i(sdi), .ser_data_o(sdo),
    .ser_data_oe_o(sdo_oe), .digit_i(digit), .mode_o(mode),
    .squelch_o(sq), .guard_sel_o(guard), .level_o(level), .tone_o(tone)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sck_pulse();
    sck = 1'b1; wait_n(6);
    sck = 1'b0; wait_n(6);
  endtask

  task automatic shift_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      sdi = w[i]; wait_n(3);
      sck_pulse();
    end
  endtask

  task automatic en_pulse();
    en = 1'b1; wait_n(8);
    en = 1'b0; wait_n(8);
  endtask

  task automatic check_fields(input string req, input logic [13:0] w);
    logic [2:0] m;
    m = (w[2:0] > 3'd5) ? 3'd4 : w[2:0];
    check(req, "tone",  8'(tone),  8'(w[13:10]));
    check(req, "level", 8'(level), 8'(w[9:6]));
    check(req, "guard", 8'(guard), 8'(w[5:4]));
    check(req, "squelch", 8'(sq),  8'(w[3]));
    check("R8", "mode", 8'(mode),  8'(m));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [13:0] w, last_w;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(10);
    // R10: reset state
    check("R10", "mode",  8'(mode), 8'h0);
    check("R10", "fields", 8'({tone, level}), 8'h0);
    check("R10", "guard/sq", 8'({guard, sq}), 8'h0);
    check("R10", "oe/sdo", 8'({sdo_oe, sdo}), 8'h0);

    // R1 R2 R8: sweep of sixteen words, all mode codes
    last_w = '0;
    for (int i = 0; i < 16; i++) begin
      w = {4'(i), 4'(15 - i), 2'(i >> 2), 1'(i), 3'(i)};
      shift_word(w);
      en_pulse();
      check_fields("R1", w);
      last_w = w;
    end

    // R3: background shift with enable low leaves outputs unchanged
    shift_word(14'h2A5B);
    check_fields("R3", last_w);
    en_pulse();
    check_fields("R2", 14'h2A5B);
    last_w = 14'h2A5B;

    // R9: serial clock edges while enable high are ignored
    shift_word(14'h1C3E);
    en = 1'b1; wait_n(8);
    for (int i = 0; i < 6; i++) begin
      sdi = 1'(i); wait_n(3);
      sck_pulse();
    end
    check_fields("R9", 14'h1C3E);
    en = 1'b0; wait_n(8);
    en_pulse();
    check_fields("R9", 14'h1C3E);

    // Read sweep over all digits
    for (int d = 0; d < 16; d++) begin
      digit = 4'(d);
      dir = 1'b1; wait_n(8);
      check("R7", "oe before enable", 8'(sdo_oe), 8'h0);
      en = 1'b1; wait_n(8);
      check("R4", "oe", 8'(sdo_oe), 8'h1);
      check("R4", "bit0", 8'(sdo), 8'(digit[0]));
      en = 1'b0; wait_n(6);
      for (int k = 1; k < 4; k++) begin
        sck_pulse();
        check("R5", "next bit", 8'(sdo), 8'((d >> k) & 1));
      end
      sck_pulse();
      check("R6", "wrap bit0", 8'(sdo), 8'(d & 1));
      digit = ~4'(d);
      wait_n(4);
      sck_pulse();
      check("R6", "held bit1", 8'(sdo), 8'((d >> 1) & 1));
      // next enable pulse captures the latest digit
      en = 1'b1; wait_n(8);
      check("R6", "new bit0", 8'(sdo), 8'((~d) & 1));
      en = 1'b0; wait_n(6);
      sck_pulse();
      check("R6", "new bit1", 8'(sdo), 8'(((~d) >> 1) & 1));
      dir = 1'b0; wait_n(8);
      check("R7", "oe/sdo after dir low", 8'({sdo_oe, sdo}), 8'h0);
    end
    // R7: back to read without enable edge, output stays off
    dir = 1'b1; wait_n(8);
    sck_pulse();
    check("R7", "oe without enable", 8'({sdo_oe, sdo}), 8'h0);
    dir = 1'b0; wait_n(8);
    // Reads leave the applied word alone
    check_fields("R3", 14'h1C3E);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule